// File: doc/BRIEF.md
# PCI Interrupt Number Mapper

This block turns a PCI device's location and interrupt pin into an interrupt line number. The device sits on one of two secondary bus segments. A request names the segment, the 5-bit slot number and the 2-bit pin code, and the registered line number comes back one clock later.

Segment B adds a fixed offset before it wraps the sum to five bits. Segment A uses the plain sum, except for two on-board slots. Those slots always get fixed legacy line numbers, and those numbers need a sixth bit.

The block also holds eight 32-bit line-routing words that software reaches through a small register window. A power-on reset loads each word with a computed start value. A soft reset only trims each word with a preserve mask and leaves the kept bits alone.

Top module: `pci_irq_mapper`

## Requirements
- R1: For a request on segment B (`req_bus`=1), `map_irq` equals (16 + slot*4 + pin) mod 32 for every slot, slot 1 and slot 3 included. Pin codes 0..3 stand for INTA..INTD.
- R2: For a request on segment A (`req_bus`=0) with a slot other than 1 or 3, `map_irq` equals (slot*4 + pin) mod 32.
- R3: On segment A, slot 1 always yields 0x21 and slot 3 always yields 0x20, whatever the pin.
- R4: `map_vld` pulses exactly one cycle after each cycle in which `req_vld` is high, and `map_irq` holds the result for that request. `map_vld` is low while `por_n` is low.
- R5: The register window covers byte offsets 0xC00..0xC3F. `reg_waddr` carries the byte offset divided by 4. An access hits a word only when byte-address bit 2 is 1, and the word index is (offset & 0x3F) >> 3.
- R6: When `por_n` is low, word i is loaded with (0x1F << 6) | (i << 2), so word 0 is 0x7C0 and word 7 is 0x7DC.
- R7: A one-cycle `soft_rst` pulse ANDs every word with the preserve mask, which defaults to 0x0000_07FC. Bits outside the mask become 0 and bits inside it keep their value.
- R8: A read that misses the window returns 0, and a write that misses it changes no word. A miss is a byte offset with bit 2 clear, or any offset outside 0xC00..0xC3F.
- R9: `rd_vld` and `rd_data` appear one cycle after `rd_en`. A word written in one cycle reads back with the new value from the next cycle on. A read in the same cycle as a write to the same word returns the old value.
- R10: When `soft_rst` and a write to a word land in the same cycle, the soft reset wins and the write data is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; loads start values |
| soft_rst | input | 1 | Soft reset pulse; trims the words with the preserve mask |
| req_vld | input | 1 | Mapping request strobe |
| req_bus | input | 1 | Bus segment: 0 = A, 1 = B |
| req_slot | input | 5 | Device slot number |
| req_pin | input | 2 | Interrupt pin code, 0..3 = INTA..INTD |
| map_vld | output | 1 | Result strobe, one cycle after the request |
| map_irq | output | 6 | Interrupt line number |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_waddr | input | 14 | Register word address (byte offset / 4) |
| wr_data | input | 32 | Write data |
| rd_vld | output | 1 | Read data strobe, one cycle after `rd_en` |
| rd_data | output | 32 | Read data, zero on a miss |

## Verification
A wrong routing word stays hidden until software reads its window offset. It then shows up in `rd_data` one cycle after the read, so the bench reads every word after each phase that could disturb it: power-up, writes, missed writes and soft reset. A wrong mapping shows up in `map_irq` on the cycle after the request. Because the mapping path holds no state, a full sweep of both segments, all slots and all pins exposes any bad entry directly. An aliasing decode fault shows up as a change in a neighbouring word, which the bench reads back right after each missed write.

// File: rtl/pim_pkg.sv
package pim_pkg;
  // Secondary bus segment selector
  typedef enum logic {
    SEG_A = 1'b0,
    SEG_B = 1'b1
  } seg_e;

  // Read response carried through the output register
  typedef struct packed {
    logic        vld;
    logic [31:0] data;
  } rd_resp_t;
endpackage

// File: rtl/pim_line_calc.sv
module pim_line_calc
  import pim_pkg::*;
#(
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned PIN_W     = 2,
  parameter int unsigned LINE_W    = 5,
  parameter int unsigned IRQ_W     = 6,
  parameter int unsigned B_OFFSET  = 16,
  parameter int unsigned NIC_SLOT  = 1,
  parameter int unsigned NIC_IRQ   = 33,
  parameter int unsigned DISK_SLOT = 3,
  parameter int unsigned DISK_IRQ  = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              req_vld,
  input  seg_e              req_seg,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [PIN_W-1:0]  req_pin,
  output logic              out_vld,
  output logic [IRQ_W-1:0]  out_irq
);

  // Slot times pin count plus pin, plus the segment offset, wrapped to LINE_W bits
  function automatic logic [LINE_W-1:0] wrapped_sum(seg_e seg,
                                                    logic [SLOT_W-1:0] s,
                                                    logic [PIN_W-1:0] p);
    logic [LINE_W-1:0] base;
    base = (seg == SEG_B) ? LINE_W'(B_OFFSET) : '0;
    return LINE_W'({s, p}) + base;
  endfunction

  function automatic logic [IRQ_W-1:0] line_of(seg_e seg,
                                               logic [SLOT_W-1:0] s,
                                               logic [PIN_W-1:0] p);
    if (seg == SEG_A && s == SLOT_W'(NIC_SLOT))
      return IRQ_W'(NIC_IRQ);
    if (seg == SEG_A && s == SLOT_W'(DISK_SLOT))
      return IRQ_W'(DISK_IRQ);
    return IRQ_W'(wrapped_sum(seg, s, p));
  endfunction

  // Named event: request lands on a fixed legacy slot
  logic legacy_hit;
  assign legacy_hit = req_vld && (req_seg == SEG_A) &&
                      ((req_slot == SLOT_W'(NIC_SLOT)) ||
                       (req_slot == SLOT_W'(DISK_SLOT)));

  logic [IRQ_W-1:0] irq_next;
  assign irq_next = line_of(req_seg, req_slot, req_pin);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      out_vld <= 1'b0;
      out_irq <= '0;
    end else begin
      out_vld <= req_vld;
      if (req_vld)
        out_irq <= irq_next;
    end
  end

  // R3
  legacy_nic_chk: assert property (@(posedge clk) disable iff (!por_n)
    (req_vld && req_seg == SEG_A && req_slot == SLOT_W'(NIC_SLOT))
      |=> (out_irq == IRQ_W'(NIC_IRQ)));

  // R3
  legacy_disk_chk: assert property (@(posedge clk) disable iff (!por_n)
    (req_vld && req_seg == SEG_A && req_slot == SLOT_W'(DISK_SLOT))
      |=> (out_irq == IRQ_W'(DISK_IRQ)));

  // R1
  seg_b_range_chk: assert property (@(posedge clk) disable iff (!por_n)
    (req_vld && req_seg == SEG_B) |=> (int'(out_irq) < (1 << LINE_W)));

  // R2
  seg_a_plain_range_chk: assert property (@(posedge clk) disable iff (!por_n)
    (req_vld && req_seg == SEG_A && !legacy_hit) |=> (int'(out_irq) < (1 << LINE_W)));

  // R4
  vld_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
    req_vld |=> out_vld);

  // R4
  vld_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    !req_vld |=> !out_vld);

endmodule

// File: rtl/pim_win_decode.sv
module pim_win_decode #(
  parameter int unsigned WADDR_W  = 14,
  parameter int unsigned NUM_MAP  = 8,
  parameter int unsigned WIN_BASE = 32'h0000_0C00
) (
  input  logic                       wr_en,
  input  logic [WADDR_W-1:0]         waddr,
  output logic                       hit,
  output logic [$clog2(NUM_MAP)-1:0] idx,
  output logic [NUM_MAP-1:0]         wr_sel
);
  localparam int unsigned IDX_W = $clog2(NUM_MAP);
  // Word-address bits inside the window: one half-select bit plus the index
  localparam int unsigned LOW_W = IDX_W + 1;
  localparam int unsigned TAG_W = WADDR_W - LOW_W;
  localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_BASE >> (LOW_W + 2));

  logic tag_match;
  logic upper_half;

  assign tag_match  = (waddr[WADDR_W-1:LOW_W] == WIN_TAG);
  assign upper_half = waddr[0];
  assign hit        = tag_match && upper_half;
  assign idx        = waddr[LOW_W-1:1];

  for (genvar g = 0; g < NUM_MAP; g++) begin : g_sel
    assign wr_sel[g] = wr_en && hit && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/pim_map_bank.sv
module pim_map_bank #(
  parameter int unsigned   NUM_MAP   = 8,
  parameter int unsigned   DATA_W    = 32,
  parameter logic [31:0]   KEEP_MASK = 32'h0000_07FC,
  parameter int unsigned   INIT_HI   = 5'h1F,
  parameter int unsigned   HI_LSB    = 6,
  parameter int unsigned   IDX_SHIFT = 2
) (
  input  logic                           clk,
  input  logic                           por_n,
  input  logic                           soft_rst,
  input  logic [NUM_MAP-1:0]             wr_sel,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_MAP-1:0][DATA_W-1:0] bank_q
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(KEEP_MASK);

  // Power-up word: upper field all ones, index placed above the low bits
  function automatic logic [DATA_W-1:0] start_word(int unsigned i);
    return DATA_W'((INIT_HI << HI_LSB) | (i << IDX_SHIFT));
  endfunction

  for (genvar g = 0; g < NUM_MAP; g++) begin : g_word
    // Named event: a write that soft reset overrides
    logic write_dropped;
    assign write_dropped = soft_rst && wr_sel[g];

    always_ff @(posedge clk) begin
      if (!por_n)
        bank_q[g] <= start_word(g);
      else if (soft_rst)
        bank_q[g] <= bank_q[g] & KEEP;
      else if (wr_sel[g])
        bank_q[g] <= wdata;
    end

    // R7
    trim_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |=> ((bank_q[g] & ~KEEP) == '0));

    // R7
    trim_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |=> ((bank_q[g] & KEEP) == ($past(bank_q[g]) & KEEP)));

    // R10
    drop_write_chk: assert property (@(posedge clk) disable iff (!por_n)
      write_dropped |=> (bank_q[g] == ($past(bank_q[g]) & KEEP)));

    // R9
    write_land_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_sel[g] && !soft_rst) |=> (bank_q[g] == $past(wdata)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!wr_sel[g] && !soft_rst) |=> $stable(bank_q[g]));
  end
endmodule

// File: rtl/pci_irq_mapper.sv
module pci_irq_mapper
  import pim_pkg::*;
#(
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned PIN_W     = 2,
  parameter int unsigned LINE_W    = 5,
  parameter int unsigned IRQ_W     = 6,
  parameter int unsigned WADDR_W   = 14,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_MAP   = 8,
  parameter int unsigned WIN_BASE  = 32'h0000_0C00,
  parameter logic [31:0] KEEP_MASK = 32'h0000_07FC
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               soft_rst,
  input  logic               req_vld,
  input  logic               req_bus,
  input  logic [SLOT_W-1:0]  req_slot,
  input  logic [PIN_W-1:0]   req_pin,
  output logic               map_vld,
  output logic [IRQ_W-1:0]   map_irq,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [WADDR_W-1:0] reg_waddr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               rd_vld,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int unsigned IDX_W = $clog2(NUM_MAP);

  pim_line_calc #(
    .SLOT_W (SLOT_W),
    .PIN_W  (PIN_W),
    .LINE_W (LINE_W),
    .IRQ_W  (IRQ_W)
  ) u_calc (
    .clk      (clk),
    .por_n    (por_n),
    .req_vld  (req_vld),
    .req_seg  (seg_e'(req_bus)),
    .req_slot (req_slot),
    .req_pin  (req_pin),
    .out_vld  (map_vld),
    .out_irq  (map_irq)
  );

  logic                           win_hit;
  logic [IDX_W-1:0]               win_idx;
  logic [NUM_MAP-1:0]             wr_sel;
  logic [NUM_MAP-1:0][DATA_W-1:0] bank_q;

  pim_win_decode #(
    .WADDR_W  (WADDR_W),
    .NUM_MAP  (NUM_MAP),
    .WIN_BASE (WIN_BASE)
  ) u_dec (
    .wr_en  (wr_en),
    .waddr  (reg_waddr),
    .hit    (win_hit),
    .idx    (win_idx),
    .wr_sel (wr_sel)
  );

  pim_map_bank #(
    .NUM_MAP   (NUM_MAP),
    .DATA_W    (DATA_W),
    .KEEP_MASK (KEEP_MASK)
  ) u_bank (
    .clk      (clk),
    .por_n    (por_n),
    .soft_rst (soft_rst),
    .wr_sel   (wr_sel),
    .wdata    (wr_data),
    .bank_q   (bank_q)
  );

  // Read path: one output register, old word returned on a same-cycle write
  logic [DATA_W-1:0] rd_word;
  assign rd_word = win_hit ? bank_q[win_idx] : '0;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en)
        rd_data <= rd_word;
    end
  end

  // R8
  miss_read_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rd_en && !win_hit) |=> (rd_data == '0));

  // R9
  read_strobe_chk: assert property (@(posedge clk) disable iff (!por_n)
    rd_en |=> rd_vld);

  // R9
  read_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rd_en |=> !rd_vld);

  // R5
  write_hit_only_chk: assert property (@(posedge clk) disable iff (!por_n)
    $countones(wr_sel) <= 1);

endmodule

// File: tb/pci_irq_mapper_tb_top.sv
module pci_irq_mapper_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        req_vld = 1'b0;
  logic        req_bus = 1'b0;
  logic [4:0]  req_slot = '0;
  logic [1:0]  req_pin = '0;
  logic        map_vld;
  logic [5:0]  map_irq;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [13:0] reg_waddr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_vld;
  logic [31:0] rd_data;

  always #2 clk = ~clk;  // 250 MHz

  pci_irq_mapper dut_i (
    .clk (clk), .por_n (por_n), .soft_rst (soft_rst),
    .req_vld (req_vld), .req_bus (req_bus), .req_slot (req_slot), .req_pin (req_pin),
    .map_vld (map_vld), .map_irq (map_irq),
    .wr_en (wr_en), .rd_en (rd_en), .reg_waddr (reg_waddr), .wr_data (wr_data),
    .rd_vld (rd_vld), .rd_data (rd_data)
  );

  typedef struct {
    longint unsigned val;
    string           tag;
  } exp_t;

  exp_t        map_q[$];
  exp_t        rd_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          reported = 1'b0;
  logic [31:0] model [8];
  localparam logic [31:0] KEEP = 32'h0000_07FC;

  task automatic note(string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Independent restatement of the mapping rules
  function automatic int want_line(bit segb, int slot, int pin);
    if (!segb && slot == 1) return 'h21;
    if (!segb && slot == 3) return 'h20;
    return ((segb ? 16 : 0) + slot * 4 + pin) % 32;
  endfunction

  function automatic bit in_window(int byte_off);
    return (byte_off >= 'hC00) && (byte_off <= 'hC3F) && ((byte_off & 4) != 0);
  endfunction

  // Monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    if (por_n) begin
      if (map_vld) begin
        if (map_q.size() == 0) note("R4 unexpected map_vld", 1, 0);
        else begin
          exp_t e;
          e = map_q.pop_front();
          note(e.tag, map_irq, e.val);
        end
      end
      if (rd_vld) begin
        if (rd_q.size() == 0) note("R9 unexpected rd_vld", 1, 0);
        else begin
          exp_t e;
          e = rd_q.pop_front();
          note(e.tag, rd_data, e.val);
        end
      end
    end
  end

  task automatic step_end();
    @(posedge clk);
    #1;
    req_vld = 1'b0; wr_en = 1'b0; rd_en = 1'b0; soft_rst = 1'b0;
  endtask

  task automatic do_map(bit segb, int slot, int pin, string tag);
    exp_t e;
    @(negedge clk); #1;
    req_vld = 1'b1; req_bus = segb; req_slot = 5'(slot); req_pin = 2'(pin);
    e.val = longint'(want_line(segb, slot, pin)); e.tag = tag;
    map_q.push_back(e);
    step_end();
  endtask

  task automatic do_read(int byte_off, string tag);
    exp_t e;
    @(negedge clk); #1;
    rd_en = 1'b1; reg_waddr = 14'(byte_off >> 2);
    e.val = in_window(byte_off) ? longint'(model[(byte_off & 'h3F) >> 3]) : 0;
    e.tag = tag;
    rd_q.push_back(e);
    step_end();
  endtask

  task automatic do_write(int byte_off, logic [31:0] d, bit with_read, bit with_trim,
                          string tag);
    exp_t e;
    @(negedge clk); #1;
    wr_en = 1'b1; reg_waddr = 14'(byte_off >> 2); wr_data = d;
    if (with_read) begin
      rd_en = 1'b1;
      e.val = in_window(byte_off) ? longint'(model[(byte_off & 'h3F) >> 3]) : 0;
      e.tag = tag;
      rd_q.push_back(e);
    end
    if (with_trim) begin
      soft_rst = 1'b1;
      for (int i = 0; i < 8; i++) model[i] = model[i] & KEEP;
    end else if (in_window(byte_off)) begin
      model[(byte_off & 'h3F) >> 3] = d;
    end
    step_end();
  endtask

  task automatic do_trim();
    @(negedge clk); #1;
    soft_rst = 1'b1;
    for (int i = 0; i < 8; i++) model[i] = model[i] & KEEP;
    step_end();
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < 8; i++) do_read('hC04 + 8 * i, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'h7C0 | (32'(i) << 2);
    repeat (3) @(negedge clk);
    note("R4 map_vld low in reset", map_vld, 0);
    note("R9 rd_vld low in reset", rd_vld, 0);
    #1 por_n = 1'b1;

    // R6: start values
    read_all("R6 power-up word");

    // R1, R2, R3: full sweep of both segments
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 32; s++)
        for (int p = 0; p < 4; p++)
          do_map(b[0], s, p,
                 (b == 1) ? "R1 segment B line" :
                 ((s == 1 || s == 3) ? "R3 legacy slot" : "R2 segment A line"));

    // R5, R9: write each word, read back
    for (int i = 0; i < 8; i++)
      do_write('hC04 + 8 * i, 32'hA500_0000 ^ (32'(i) * 32'h0101_0101), 0, 0, "");
    read_all("R5 R9 write then read");

    // R9: same-cycle read returns old word
    do_write('hC24, 32'h1357_9BDF, 1, 0, "R9 read during write is old");
    do_read('hC24, "R9 new word next cycle");

    // R8: misses read zero and writes change nothing
    do_read('hC00, "R8 bit2 clear reads zero");
    do_read('hC38, "R8 bit2 clear reads zero");
    do_read('h1C04, "R8 outside window reads zero");
    do_write('hC00, 32'hDEAD_BEEF, 0, 0, "");
    do_write('hC44, 32'hDEAD_BEEF, 0, 0, "");
    do_write('h1C04, 32'hDEAD_BEEF, 0, 0, "");
    do_write('hC10, 32'hDEAD_BEEF, 0, 0, "");
    read_all("R8 missed write ignored");

    // R7: soft reset trims with preserve mask
    do_write('hC14, 32'hFFFF_FFFF, 0, 0, "");
    do_write('hC2C, 32'h1234_5678, 0, 0, "");
    do_trim();
    read_all("R7 trimmed word");

    // R10: soft reset beats a same-cycle write
    do_write('hC34, 32'hFFFF_FFFF, 0, 0, "");
    do_write('hC34, 32'h0F0F_0F0F, 0, 1, "");
    do_read('hC34, "R10 write dropped under soft reset");
    read_all("R10 other words after trim");

    // R4: back-to-back requests after register traffic
    do_map(1'b0, 1, 2, "R3 legacy slot after trim");
    do_map(1'b1, 31, 3, "R1 wrap on segment B");
    do_map(1'b0, 7, 1, "R2 segment A line");

    repeat (4) @(negedge clk);
    note("R4 no pending map results", map_q.size(), 0);
    note("R9 no pending read results", rd_q.size(), 0);
    report();
  end
endmodule